// File: doc/BRIEF.md
# Floppy Controller Host Sequencer

This block is the host-side sequencer of a two-drive floppy controller. The processor reaches it through seven numbered I/O pulses, each carrying an accumulator word. One pulse loads a command word. The other pulses move a word through the data register, test and clear the transfer-ready, error and done flags, set the interrupt enable, and reinitialise the controller. Every pulse gets a registered response one cycle later: the accumulator value to return and a skip indication.

Once a command is latched, the sequencer runs its multi-word handshake. Each data word the host must supply or collect is offered by raising transfer-ready. The block does not hold sector data and does not touch the medium. It hands words to a separate buffer datapath through a word request/acknowledge pair. It starts a separate medium engine with a start strobe that carries the track and sector, or with an initialise strobe, and it waits for that engine's completion and error code. Commands that only report state finish after a fixed command delay.

Top module: `fdc_host_seq`

## Requirements
- R1: A load-command pulse (code 1) in the idle state latches the accumulator as the command, clears done, error and transfer-ready, strobes `buf_clr` and returns zero. In any other state the pulse is ignored: the command is unchanged and the accumulator is returned as given.
- R2: The command fields are decoded as follows: function = bits 3:1 (0 fill, 1 empty, 2 write, 3 read, 4 set density, 5 read status, 6 write deleted, 7 read error code), drive = bit 4, byte mode = bit 6, double density = bit 8.
- R3: When `ext_mode` is high and accumulator bit 6 is set, a load keeps only the low 8 bits and sets transfer-ready. The next data-transfer pulse (code 2) supplies command bits 11:8 from its low 4 bits, and the command is then dispatched.
- R4: Read, write and write-deleted each raise transfer-ready twice. The first transfer word gives the sector (bits 6:0) and the second gives the track (bits 7:0). `med_start` then fires, and `med_done` ends the command with `med_err` as its error code.
- R5: Fill raises transfer-ready. Each transfer word is stored in the data register and sent with `word_req`. An acknowledge without `word_last` raises transfer-ready again; an acknowledge with `word_last` completes the command.
- R6: Empty issues `word_req` at the start and after every transfer pulse. An acknowledge without `word_last` loads `word_data` into the data register and raises transfer-ready. An acknowledge with `word_last` completes the command.
- R7: Set density with `ext_mode` high raises transfer-ready for a confirmation word. Low byte 0x49 (octal 111) starts the medium engine. Any other value completes at once with error code 0xA8 (octal 250).
- R8: Read status, read error code, and set density with `ext_mode` low never raise transfer-ready. They complete only after `CMD_DELAY` cycles.
- R9: Completion returns to idle and sets done. A nonzero code sets the error flag. Every command except read error code stores its code as the error code and loads `status_in` into the data register. Read error code instead loads the stored error code into the data register and leaves it unchanged.
- R10: The skip-on-ready (code 3) and skip-on-error (code 4) pulses skip and clear their flag only when it is set. Skip-on-done (code 5) does the same for done, which also removes the interrupt request.
- R11: The interrupt-enable pulse (code 6) copies accumulator bit 0 into the enable. `irq` is high exactly when done and the enable are both set.
- R12: A data-transfer pulse while idle, emptying or busy returns a value that depends on byte mode. In byte mode it is the accumulator with the data register's low 8 bits ORed in. Otherwise it is the full data register.
- R13: The initialise pulse (code 7) clears the command, data register, flags, enable and error code, strobes `med_init`, and completes on `med_done` with `med_err` as its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Enables two-part entry and density confirmation |
| pulse_valid | input | 1 | An I/O pulse is present this cycle |
| pulse_code | input | 3 | Pulse number 1..7 |
| acc_in | input | WORD_W | Accumulator value carried by the pulse |
| resp_valid | output | 1 | Response to last cycle's pulse |
| resp_acc | output | WORD_W | Accumulator value returned |
| resp_skip | output | 1 | Skip condition returned |
| xfer_ready | output | 1 | Transfer-ready flag |
| err_flag | output | 1 | Error flag |
| done_flag | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |
| data_reg | output | WORD_W | Interface data register |
| cmd_func | output | 3 | Decoded function |
| cmd_drive | output | 1 | Selected drive |
| cmd_byte_mode | output | 1 | 8-bit transfer mode |
| cmd_dbl_den | output | 1 | Double density requested |
| buf_clr | output | 1 | Strobe: reset buffer pointer |
| word_req | output | 1 | Strobe: buffer takes or gives one word |
| word_ack | input | 1 | Buffer answer to word_req |
| word_last | input | 1 | Buffer has no further words |
| word_data | input | WORD_W | Word read from the buffer |
| med_start | output | 1 | Strobe: start sector or density operation |
| med_init | output | 1 | Strobe: start the initialise sequence |
| med_track | output | TRACK_W | Track for the medium engine |
| med_sector | output | SECT_W | Sector for the medium engine |
| med_done | input | 1 | Medium engine finished |
| med_err | input | CODE_W | Error code from the medium engine |
| status_in | input | STAT_W | Drive status word reported on completion |

## Verification
The in-line assertions check on every cycle that no load changes a latched command while the block is busy, and that a skip never appears for a flag that was clear. They also check that the error flag only rises together with done, that an interrupt only rises in idle, that at most one downstream strobe fires at a time, and that the delay counter only counts down. The order of sector before track and the confirmation byte value can only be shown by the directed scenarios. So can the two-part command assembly, the byte-mode merge of the returned value, and the data-register contents at completion, including the error-code readback.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  // Pulse numbers as seen on pulse_code
  localparam int P_LOAD  = 1;
  localparam int P_XFER  = 2;
  localparam int P_SKTR  = 3;
  localparam int P_SKERR = 4;
  localparam int P_SKDN  = 5;
  localparam int P_IEN   = 6;
  localparam int P_INIT  = 7;

  // Command word fields
  localparam int FUNC_LSB  = 1;
  localparam int DRIVE_BIT = 4;
  localparam int BYTE_BIT  = 6;
  localparam int DEN_BIT   = 8;

  typedef enum logic [2:0] {
    F_FILL   = 3'd0,
    F_EMPTY  = 3'd1,
    F_WRITE  = 3'd2,
    F_READ   = 3'd3,
    F_SETDEN = 3'd4,
    F_STATUS = 3'd5,
    F_WRDEL  = 3'd6,
    F_ECODE  = 3'd7
  } func_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DISPATCH, S_CMD8, S_FILL, S_FILLW, S_EMPTY, S_EMPTYW,
    S_WSECT, S_WTRACK, S_MEDIA, S_CONF, S_DELAY, S_INITW
  } seq_state_e;

  localparam logic [7:0] CONFIRM_BYTE  = 8'h49;
  localparam logic [7:0] BAD_CONF_CODE = 8'hA8;
endpackage

// File: rtl/fdc_pulse_dec.sv
module fdc_pulse_dec #(
  parameter int CODE_W = 3,
  localparam int NSTB = (1 << CODE_W) - 1
) (
  input  logic              pulse_valid,
  input  logic [CODE_W-1:0] pulse_code,
  output logic [NSTB:1]     strobe
);
  // Code 0 is unused; every other code gets its own strobe
  for (genvar i = 1; i <= NSTB; i++) begin : g_stb
    assign strobe[i] = pulse_valid && (pulse_code == CODE_W'(i));
  end
endmodule

// File: rtl/fdc_cmd_reg.sv
module fdc_cmd_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld_full,
  input  logic         ld_low,
  input  logic         ld_high,
  input  logic [W-1:0] din,
  output logic [W-1:0] cmd
);
  always_ff @(posedge clk) begin
    if (rst || clr)   cmd <= '0;
    else if (ld_full) cmd <= din;
    else if (ld_low)  cmd <= {{(W-8){1'b0}}, din[7:0]};
    else if (ld_high) cmd[W-1:8] <= din[W-9:0];
  end
endmodule

// File: rtl/fdc_delay_timer.sv
module fdc_delay_timer #(
  parameter int CMD_DELAY = 16,
  localparam int CW = $clog2(CMD_DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (start)      cnt <= CW'(CMD_DELAY);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == CW'(1));

  // R8
  delay_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !clr && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
  import fdc_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int TRACK_W   = 8,
  parameter int SECT_W    = 7,
  parameter int CODE_W    = 8,
  parameter int STAT_W    = 8,
  parameter int CMD_DELAY = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_mode,
  input  logic               pulse_valid,
  input  logic [2:0]         pulse_code,
  input  logic [WORD_W-1:0]  acc_in,
  output logic               resp_valid,
  output logic [WORD_W-1:0]  resp_acc,
  output logic               resp_skip,
  output logic               xfer_ready,
  output logic               err_flag,
  output logic               done_flag,
  output logic               irq,
  output logic [WORD_W-1:0]  data_reg,
  output logic [2:0]         cmd_func,
  output logic               cmd_drive,
  output logic               cmd_byte_mode,
  output logic               cmd_dbl_den,
  output logic               buf_clr,
  output logic               word_req,
  input  logic               word_ack,
  input  logic               word_last,
  input  logic [WORD_W-1:0]  word_data,
  output logic               med_start,
  output logic               med_init,
  output logic [TRACK_W-1:0] med_track,
  output logic [SECT_W-1:0]  med_sector,
  input  logic               med_done,
  input  logic [CODE_W-1:0]  med_err,
  input  logic [STAT_W-1:0]  status_in
);
  localparam int CFW = (CODE_W > 8) ? CODE_W : 8;

  logic [7:1] stb;
  logic p_ld, p_xdr, p_str, p_ser, p_sdn, p_ien, p_init;

  fdc_pulse_dec #(.CODE_W(3)) u_dec (
    .pulse_valid(pulse_valid), .pulse_code(pulse_code), .strobe(stb));

  assign p_ld   = stb[P_LOAD];
  assign p_xdr  = stb[P_XFER];
  assign p_str  = stb[P_SKTR];
  assign p_ser  = stb[P_SKERR];
  assign p_sdn  = stb[P_SKDN];
  assign p_ien  = stb[P_IEN];
  assign p_init = stb[P_INIT];

  // State and next-state registers
  seq_state_e          state_q, state_n;
  logic [WORD_W-1:0]   dbr_q, dbr_n, resp_acc_n;
  logic [TRACK_W-1:0]  track_q, track_n;
  logic [SECT_W-1:0]   sect_q, sect_n;
  logic [CODE_W-1:0]   ecode_q, ecode_n;
  logic tr_q, tr_n, err_q, err_n, done_q, done_n, ie_q, ie_n;
  logic resp_skip_n, buf_clr_n, word_req_n, med_start_n, med_init_n;

  // Command register controls
  logic [WORD_W-1:0] cmd;
  logic cmd_clr, cmd_full, cmd_low, cmd_high;
  logic dly_start, dly_exp;

  // Completion controls
  logic              fin, fin_keep;
  logic [CODE_W-1:0] fin_code;
  logic [WORD_W-1:0] rd_val;
  logic              two_part;

  fdc_cmd_reg #(.W(WORD_W)) u_cmd (
    .clk(clk), .rst(rst), .clr(cmd_clr), .ld_full(cmd_full),
    .ld_low(cmd_low), .ld_high(cmd_high), .din(acc_in), .cmd(cmd));

  fdc_delay_timer #(.CMD_DELAY(CMD_DELAY)) u_dly (
    .clk(clk), .rst(rst), .clr(p_init), .start(dly_start), .expired(dly_exp));

  assign cmd_func      = cmd[FUNC_LSB +: 3];
  assign cmd_drive     = cmd[DRIVE_BIT];
  assign cmd_byte_mode = cmd[BYTE_BIT];
  assign cmd_dbl_den   = cmd[DEN_BIT];

  assign rd_val   = cmd_byte_mode ? {acc_in[WORD_W-1:8], acc_in[7:0] | dbr_q[7:0]} : dbr_q;
  assign two_part = ext_mode && acc_in[BYTE_BIT];

  always_comb begin
    state_n = state_q;  dbr_n = dbr_q;  track_n = track_q;  sect_n = sect_q;
    ecode_n = ecode_q;  tr_n = tr_q;    err_n = err_q;      done_n = done_q;
    ie_n = ie_q;
    resp_acc_n = acc_in; resp_skip_n = 1'b0;
    buf_clr_n = 1'b0; word_req_n = 1'b0; med_start_n = 1'b0; med_init_n = 1'b0;
    cmd_clr = 1'b0; cmd_full = 1'b0; cmd_low = 1'b0; cmd_high = 1'b0;
    dly_start = 1'b0;
    fin = 1'b0; fin_keep = 1'b0; fin_code = '0;

    // Flag tests consume the old flag value; events below may set it again
    if (p_str && tr_q)   begin tr_n   = 1'b0; resp_skip_n = 1'b1; end
    if (p_ser && err_q)  begin err_n  = 1'b0; resp_skip_n = 1'b1; end
    if (p_sdn && done_q) begin done_n = 1'b0; resp_skip_n = 1'b1; end
    if (p_ien) ie_n = acc_in[0];

    unique case (state_q)
      S_IDLE: begin
        if (p_xdr) resp_acc_n = rd_val;
        if (p_ld) begin
          done_n = 1'b0; err_n = 1'b0; buf_clr_n = 1'b1; resp_acc_n = '0;
          if (two_part) begin
            cmd_low = 1'b1; dbr_n = {{(WORD_W-8){1'b0}}, acc_in[7:0]};
            tr_n = 1'b1; state_n = S_CMD8;
          end else begin
            cmd_full = 1'b1; dbr_n = acc_in; tr_n = 1'b0; state_n = S_DISPATCH;
          end
        end
      end
      S_DISPATCH: begin
        if (p_xdr) resp_acc_n = rd_val;
        unique case (func_e'(cmd_func))
          F_FILL:  begin tr_n = 1'b1; state_n = S_FILL; end
          F_EMPTY: begin word_req_n = 1'b1; state_n = S_EMPTYW; end
          F_WRITE, F_READ, F_WRDEL: begin tr_n = 1'b1; state_n = S_WSECT; end
          F_SETDEN: begin
            if (ext_mode) begin tr_n = 1'b1; state_n = S_CONF; end
            else begin dly_start = 1'b1; state_n = S_DELAY; end
          end
          default: begin dly_start = 1'b1; state_n = S_DELAY; end
        endcase
      end
      S_CMD8: if (p_xdr) begin
        dbr_n = {{(WORD_W-8){1'b0}}, dbr_q[7:0]};
        cmd_high = 1'b1; state_n = S_DISPATCH;
      end
      S_FILL: if (p_xdr) begin
        dbr_n = acc_in; word_req_n = 1'b1; state_n = S_FILLW;
      end
      S_FILLW: begin
        if (p_xdr) resp_acc_n = rd_val;
        if (word_ack) begin
          if (word_last) fin = 1'b1;
          else begin tr_n = 1'b1; state_n = S_FILL; end
        end
      end
      S_EMPTY: if (p_xdr) begin
        resp_acc_n = rd_val; word_req_n = 1'b1; state_n = S_EMPTYW;
      end
      S_EMPTYW: begin
        if (p_xdr) resp_acc_n = rd_val;
        if (word_ack) begin
          if (word_last) fin = 1'b1;
          else begin dbr_n = word_data; tr_n = 1'b1; state_n = S_EMPTY; end
        end
      end
      S_WSECT: if (p_xdr) begin
        dbr_n = acc_in; sect_n = acc_in[SECT_W-1:0]; tr_n = 1'b1; state_n = S_WTRACK;
      end
      S_WTRACK: if (p_xdr) begin
        dbr_n = acc_in; track_n = acc_in[TRACK_W-1:0];
        med_start_n = 1'b1; state_n = S_MEDIA;
      end
      S_CONF: if (p_xdr) begin
        dbr_n = acc_in;
        if (acc_in[7:0] != CONFIRM_BYTE) begin
          fin = 1'b1; fin_code = CODE_W'(CFW'(BAD_CONF_CODE));
        end else begin
          med_start_n = 1'b1; state_n = S_MEDIA;
        end
      end
      S_MEDIA, S_INITW: begin
        if (p_xdr) resp_acc_n = rd_val;
        if (med_done) begin fin = 1'b1; fin_code = med_err; end
      end
      S_DELAY: begin
        if (p_xdr) resp_acc_n = rd_val;
        if (dly_exp) begin fin = 1'b1; fin_keep = (func_e'(cmd_func) == F_ECODE); end
      end
      default: state_n = S_IDLE;
    endcase

    if (fin) begin
      state_n = S_IDLE; done_n = 1'b1;
      if (fin_code != '0) err_n = 1'b1;
      if (fin_keep) dbr_n = {{(WORD_W-CODE_W){1'b0}}, ecode_q};
      else begin
        ecode_n = fin_code;
        dbr_n = {{(WORD_W-STAT_W){1'b0}}, status_in};
      end
    end

    if (p_init) begin
      state_n = S_INITW; dbr_n = '0; track_n = '0; sect_n = '0; ecode_n = '0;
      tr_n = 1'b0; err_n = 1'b0; done_n = 1'b0; ie_n = 1'b0;
      cmd_clr = 1'b1; cmd_full = 1'b0; cmd_low = 1'b0; cmd_high = 1'b0;
      dly_start = 1'b0; word_req_n = 1'b0; med_start_n = 1'b0;
      med_init_n = 1'b1; buf_clr_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE; dbr_q <= '0; track_q <= '0; sect_q <= '0; ecode_q <= '0;
      tr_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0; ie_q <= 1'b0;
      resp_valid <= 1'b0; resp_acc <= '0; resp_skip <= 1'b0;
      buf_clr <= 1'b0; word_req <= 1'b0; med_start <= 1'b0; med_init <= 1'b0;
    end else begin
      state_q <= state_n; dbr_q <= dbr_n; track_q <= track_n; sect_q <= sect_n;
      ecode_q <= ecode_n; tr_q <= tr_n; err_q <= err_n; done_q <= done_n;
      ie_q <= ie_n;
      resp_valid <= pulse_valid; resp_acc <= resp_acc_n; resp_skip <= resp_skip_n;
      buf_clr <= buf_clr_n; word_req <= word_req_n;
      med_start <= med_start_n; med_init <= med_init_n;
    end
  end

  assign xfer_ready = tr_q;
  assign err_flag   = err_q;
  assign done_flag  = done_q;
  assign irq        = done_q && ie_q;
  assign data_reg   = dbr_q;
  assign med_track  = track_q;
  assign med_sector = sect_q;

  // R1
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (p_ld && !p_init && state_q != S_IDLE) |=> $stable(cmd));
  // R10
  skip_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (p_str && !tr_q) |=> !resp_skip);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $rose(done_q));
  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (state_q == S_IDLE));
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({word_req, med_start, med_init}));
  // R4
  start_in_media_chk: assert property (@(posedge clk) disable iff (rst)
    med_start |-> (state_q == S_MEDIA));
endmodule

// File: tb/fdc_host_seq_tb.sv
module fdc_host_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ext_mode = 1'b0, pulse_valid = 1'b0;
  logic [2:0] pulse_code = '0;
  logic [11:0] acc_in = '0;
  logic resp_valid, resp_skip, xfer_ready, err_flag, done_flag, irq;
  logic [11:0] resp_acc, data_reg, word_data = '0;
  logic [2:0] cmd_func;
  logic cmd_drive, cmd_byte_mode, cmd_dbl_den, buf_clr, word_req;
  logic word_ack = 1'b0, word_last = 1'b0, med_done = 1'b0;
  logic med_start, med_init;
  logic [7:0] med_track, med_err = '0, status_in = 8'h84;
  logic [6:0] med_sector;

  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_host_seq #(.CMD_DELAY(DLY)) u_dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .pulse_valid(pulse_valid),
    .pulse_code(pulse_code), .acc_in(acc_in), .resp_valid(resp_valid),
    .resp_acc(resp_acc), .resp_skip(resp_skip), .xfer_ready(xfer_ready),
    .err_flag(err_flag), .done_flag(done_flag), .irq(irq), .data_reg(data_reg),
    .cmd_func(cmd_func), .cmd_drive(cmd_drive), .cmd_byte_mode(cmd_byte_mode),
    .cmd_dbl_den(cmd_dbl_den), .buf_clr(buf_clr), .word_req(word_req),
    .word_ack(word_ack), .word_last(word_last), .word_data(word_data),
    .med_start(med_start), .med_init(med_init), .med_track(med_track),
    .med_sector(med_sector), .med_done(med_done), .med_err(med_err),
    .status_in(status_in));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] code, input logic [11:0] acc);
    @(negedge clk);
    pulse_valid = 1'b1; pulse_code = code; acc_in = acc;
    @(negedge clk);
    pulse_valid = 1'b0; pulse_code = '0; acc_in = '0;
  endtask

  function automatic logic cond(input int sel);
    case (sel)
      0: return xfer_ready;
      1: return done_flag;
      2: return word_req;
      3: return med_start;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_until(input string req, input int sel);
    for (int i = 0; i < 100; i++) begin
      if (cond(sel)) break;
      @(negedge clk);
    end
    chk(req, 12'(cond(sel)), 12'd1);
  endtask

  task automatic buf_answer(input logic [11:0] d, input logic last);
    @(negedge clk); word_ack = 1'b1; word_data = d; word_last = last;
    @(negedge clk); word_ack = 1'b0; word_last = 1'b0;
  endtask

  task automatic media_answer(input logic [7:0] code);
    @(negedge clk); med_done = 1'b1; med_err = code;
    @(negedge clk); med_done = 1'b0; med_err = '0;
  endtask

  task automatic t_reset();
    chk("R13 reset done", 12'(done_flag), 0);
    chk("R13 reset tr", 12'(xfer_ready), 0);
    chk("R13 reset data", data_reg, 0);
  endtask

  task automatic t_status();
    // read status, drive 1, double density: 0x100|0x10|(5<<1)
    pulse(3'd1, 12'h11A);
    chk("R1 load returns zero", resp_acc, 0);
    chk("R2 func", 12'(cmd_func), 5);
    chk("R2 drive", 12'(cmd_drive), 1);
    chk("R2 density", 12'(cmd_dbl_den), 1);
    repeat (3) @(negedge clk);
    chk("R8 not early", 12'(done_flag), 0);
    wait_until("R8 status completes", 1);
    chk("R8 no transfer-ready", 12'(xfer_ready), 0);
    chk("R9 status in data", data_reg, 12'h084);
    pulse(3'd2, 12'hF00);
    chk("R12 word-mode read", resp_acc, 12'h084);
  endtask

  task automatic t_rw_error();
    pulse(3'd1, 12'h006);
    wait_until("R4 sector ready", 0);
    pulse(3'd3, 12'h000);
    chk("R10 skip on ready", 12'(resp_skip), 1);
    pulse(3'd3, 12'h000);
    chk("R10 no skip when clear", 12'(resp_skip), 0);
    pulse(3'd2, 12'h005);
    wait_until("R4 track ready", 0);
    pulse(3'd2, 12'h028);
    wait_until("R4 start", 3);
    chk("R4 sector", 12'(med_sector), 5);
    chk("R4 track", 12'(med_track), 12'h028);
    pulse(3'd1, 12'h00A);
    chk("R1 busy load echoes", resp_acc, 12'h00A);
    chk("R1 busy load ignored", 12'(cmd_func), 3);
    media_answer(8'h70);
    chk("R4 done", 12'(done_flag), 1);
    chk("R9 error flag", 12'(err_flag), 1);
    pulse(3'd4, 12'h000);
    chk("R10 skip on error", 12'(resp_skip), 1);
    chk("R10 error cleared", 12'(err_flag), 0);
    pulse(3'd1, 12'h00E);
    wait_until("R8 ecode completes", 1);
    chk("R9 ecode readback", data_reg, 12'h070);
  endtask

  task automatic t_fill();
    pulse(3'd1, 12'h000);
    wait_until("R5 fill ready", 0);
    pulse(3'd2, 12'hABC);
    wait_until("R5 word request", 2);
    chk("R5 word stored", data_reg, 12'hABC);
    buf_answer(12'h000, 1'b0);
    chk("R5 ready again", 12'(xfer_ready), 1);
    pulse(3'd2, 12'h123);
    wait_until("R5 second request", 2);
    buf_answer(12'h000, 1'b1);
    chk("R5 last word completes", 12'(done_flag), 1);
  endtask

  task automatic t_empty();
    pulse(3'd1, 12'h042);
    wait_until("R6 first request", 2);
    buf_answer(12'h0C5, 1'b0);
    chk("R6 ready", 12'(xfer_ready), 1);
    chk("R6 data loaded", data_reg, 12'h0C5);
    pulse(3'd2, 12'h300);
    chk("R12 byte-mode merge", resp_acc, 12'h3C5);
    wait_until("R6 next request", 2);
    buf_answer(12'h000, 1'b1);
    chk("R6 completes", 12'(done_flag), 1);
  endtask

  task automatic t_two_part();
    ext_mode = 1'b1;
    pulse(3'd1, 12'hF48);
    chk("R3 low byte only", data_reg, 12'h048);
    chk("R3 ready for high part", 12'(xfer_ready), 1);
    chk("R3 density not yet", 12'(cmd_dbl_den), 0);
    pulse(3'd2, 12'h001);
    chk("R3 high bits", 12'(cmd_dbl_den), 1);
    wait_until("R7 confirm ready", 0);
    pulse(3'd2, 12'h049);
    wait_until("R7 start on confirm", 3);
    media_answer(8'h00);
    chk("R7 done", 12'(done_flag), 1);
    chk("R7 no error", 12'(err_flag), 0);
    pulse(3'd1, 12'h008);
    wait_until("R7 confirm ready plain", 0);
    pulse(3'd2, 12'h048);
    chk("R7 bad confirm done", 12'(done_flag), 1);
    chk("R7 bad confirm error", 12'(err_flag), 1);
    ext_mode = 1'b0;
    pulse(3'd1, 12'h00E);
    wait_until("R9 ecode after bad confirm", 1);
    chk("R7 code A8", data_reg, 12'h0A8);
    pulse(3'd1, 12'h008);
    repeat (2) @(negedge clk);
    chk("R8 set density no ready", 12'(xfer_ready), 0);
    wait_until("R8 set density delay", 1);
  endtask

  task automatic t_irq();
    pulse(3'd6, 12'h001);
    chk("R11 irq raised", 12'(irq), 1);
    pulse(3'd5, 12'h000);
    chk("R10 skip on done", 12'(resp_skip), 1);
    chk("R10 irq cleared", 12'(irq), 0);
    pulse(3'd5, 12'h000);
    chk("R10 no second skip", 12'(resp_skip), 0);
    pulse(3'd6, 12'h000);
  endtask

  task automatic t_init();
    pulse(3'd6, 12'h001);
    pulse(3'd7, 12'h000);
    chk("R13 init strobe", 12'(med_init), 1);
    chk("R13 data cleared", data_reg, 0);
    media_answer(8'h10);
    chk("R13 init done", 12'(done_flag), 1);
    chk("R13 enable cleared", 12'(irq), 0);
    chk("R13 init error", 12'(err_flag), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_rw_error();
    t_fill();
    t_empty();
    t_two_part();
    t_irq();
    t_init();
    summary();
    $finish;
  end
endmodule